// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI bridge's configuration header. It records two bus events as sticky flags. The first is a data parity error that the bridge sees while it is bus master. The second is a target-abort that the bridge itself signals while it is target. The word also reports fixed capability fields. Configuration software reads the word through a combinational read port. It clears event flags by writing ones through a write strobe with one enable per byte lane.

A separate local-processor port loads the 66 MHz capability flag once the bridge's bus speed is known. Event inputs are one-cycle pulses from the bus-side logic, synchronous to the PCI clock. The parity-error response enable comes in from the command register and gates parity-error capture. Address decoding, the command register and the bus state machines sit outside this block.

Top module: `pci_stat_reg`

## Requirements
- R1: After reset the read word is 16'h0200.
- R2: Bits 4:0, 7:6 and 15:12 always read 0, and bits 10:9 always read 2'b01. Configuration writes to these bits have no effect.
- R3: A local-processor write (`lp_wr`=1) loads bit 5 from `lp_cap66` at the next clock. Configuration writes never change bit 5.
- R4: Bit 8 becomes 1 after a clock in which `mst_perr`=1 and `perr_resp_en`=1. A `mst_perr` pulse while `perr_resp_en`=0 leaves bit 8 unchanged.
- R5: Bit 11 becomes 1 after a clock in which `tgt_abort`=1.
- R6: A configuration write with `cfg_be[1]`=1 clears bit 8 and/or bit 11 where the matching `cfg_wdata` bit is 1. Where the data bit is 0 the flag is unchanged. With `cfg_be[1]`=0 the write clears neither flag.
- R7: If a set event and a write-1 clear hit the same flag in the same clock, the flag ends up 1.
- R8: Event flags hold their value until a write-1 clear. `cfg_rdata` shows the register state without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables: [0] for bits 7:0, [1] for bits 15:8 |
| cfg_wdata | input | 16 | Configuration write data (1 = clear flag) |
| cfg_rdata | output | 16 | Status word read data |
| lp_wr | input | 1 | Local-processor write strobe for the speed flag |
| lp_cap66 | input | 1 | Value to load into the 66 MHz capability flag |
| mst_perr | input | 1 | Pulse: master sampled a parity-error signal on its read or write |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| tgt_abort | input | 1 | Pulse: target ended a cycle with target-abort |

## Verification
Directed cases come first. One sends a parity-error pulse with the response enable both low and high, which separates gated capture from plain capture. One sends clear writes with the upper byte enable off, and with only one data bit set, which shows per-lane and per-bit qualification. One lands an event and its clear in the same clock, which shows that the set has priority. A long run of random strobes, data, enables and events follows. After each run it compares the whole word against a bench model. This checks that the fixed fields stay put under any configuration write, and that the speed flag moves only when the local processor writes it.

// File: rtl/pci_stat_reg.sv
module pci_stat_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        lp_wr,
  input  logic        lp_cap66,
  input  logic        mst_perr,
  input  logic        perr_resp_en,
  input  logic        tgt_abort
);

  logic cap66_q, perr_q, tabort_q;

  wire hi_clr   = cfg_wr & cfg_be[1];
  wire perr_set = mst_perr & perr_resp_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap66_q  <= 1'b0;
      perr_q   <= 1'b0;
      tabort_q <= 1'b0;
    end else begin
      if (lp_wr) cap66_q <= lp_cap66;
      if (perr_set)                   perr_q <= 1'b1;
      else if (hi_clr & cfg_wdata[8]) perr_q <= 1'b0;
      if (tgt_abort)                   tabort_q <= 1'b1;
      else if (hi_clr & cfg_wdata[11]) tabort_q <= 1'b0;
    end
  end

  assign cfg_rdata = {4'b0000, tabort_q, 2'b01, perr_q, 2'b00, cap66_q, 5'b00000};

  a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4:0] == 5'd0) && (cfg_rdata[7:6] == 2'd0) &&
    (cfg_rdata[15:12] == 4'd0) && (cfg_rdata[10:9] == 2'b01));

  a_r3_lp_load: assert property (@(posedge clk) disable iff (!rst_n)
    lp_wr |=> cfg_rdata[5] == $past(lp_cap66));

  a_r3_cfg_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_wr |=> $stable(cfg_rdata[5]));

  a_r4_perr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_perr && perr_resp_en) |=> cfg_rdata[8]);

  a_r5_tabort_set: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_abort |=> cfg_rdata[11]);

  a_r6_perr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be[1] && cfg_wdata[8] && !(mst_perr && perr_resp_en)) |=> !cfg_rdata[8]);

  a_r8_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[8] && !(cfg_wr && cfg_be[1] && cfg_wdata[8])) |=> cfg_rdata[8]);

  a_r8_tabort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[11] && !(cfg_wr && cfg_be[1] && cfg_wdata[11])) |=> cfg_rdata[11]);

endmodule

// File: tb/pci_stat_reg_tb_top.sv
module pci_stat_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, lp_wr = 0, lp_cap66 = 0, mst_perr = 0, perr_resp_en = 0, tgt_abort = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  int n_chk = 0, n_bad = 0;
  bit m_c66, m_pe, m_ta;
  bit done = 0;

  always #5 clk = ~clk;

  pci_stat_reg dut_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lp_wr(lp_wr), .lp_cap66(lp_cap66),
    .mst_perr(mst_perr), .perr_resp_en(perr_resp_en), .tgt_abort(tgt_abort));

  function automatic logic [15:0] exp_word(bit c, bit p, bit t);
    return {4'b0, t, 2'b01, p, 2'b00, c, 5'b0};
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(bit w, logic [1:0] be, logic [15:0] d, bit lw, bit lc, bit pe, bit en, bit ta);
    cfg_wr = w; cfg_be = be; cfg_wdata = d; lp_wr = lw; lp_cap66 = lc;
    mst_perr = pe; perr_resp_en = en; tgt_abort = ta;
    if (lw) m_c66 = lc;
    if (pe && en) m_pe = 1;
    else if (w && be[1] && d[8]) m_pe = 0;
    if (ta) m_ta = 1;
    else if (w && be[1] && d[11]) m_ta = 0;
    @(negedge clk);
    cfg_wr = 0; lp_wr = 0; mst_perr = 0; tgt_abort = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset", cfg_rdata, 16'h0200);
    step(1, 2'b11, 16'hFFFF, 0, 0, 0, 0, 0);
    chk("R2 write all ones ignored", cfg_rdata, 16'h0200);
    chk("R3 cfg write leaves bit5", cfg_rdata[5], 1'b0);
    step(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R3 lp load 1", cfg_rdata, 16'h0220);
    step(1, 2'b11, 16'h0000, 0, 0, 0, 0, 0);
    chk("R3 cfg write zero keeps bit5", cfg_rdata, 16'h0220);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 gated by enable", cfg_rdata, 16'h0220);
    step(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R4 perr captured", cfg_rdata, 16'h0320);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R5 target abort", cfg_rdata, 16'h0B20);
    repeat (3) step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 sticky", cfg_rdata, 16'h0B20);
    step(1, 2'b01, 16'hFFFF, 0, 0, 0, 0, 0);
    chk("R6 low lane only no clear", cfg_rdata, 16'h0B20);
    step(1, 2'b10, 16'h0800, 0, 0, 0, 0, 0);
    chk("R6 clear bit11 only", cfg_rdata, 16'h0320);
    step(1, 2'b10, 16'h0100, 0, 0, 1, 1, 0);
    chk("R7 set beats clear bit8", cfg_rdata, 16'h0320);
    step(1, 2'b10, 16'h0800, 0, 0, 0, 0, 1);
    chk("R7 set beats clear bit11", cfg_rdata, 16'h0B20);
    step(1, 2'b10, 16'h0900, 0, 0, 0, 0, 0);
    chk("R6 clear both", cfg_rdata, 16'h0220);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 lp load 0", cfg_rdata, 16'h0200);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], r[2:1], $urandom, r[3] & r[4], r[5], r[6] & r[7], r[8], r[9] & r[10] & r[11]);
      chk("R8 random vs model", cfg_rdata, exp_word(m_c66, m_pe, m_ta));
    end
    done = 1;
  end

  initial begin
    m_c66 = 0; m_pe = 0; m_ta = 0;
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule